// File: doc/BRIEF.md
# Oversampling Serial Receiver with DMA Request

This block receives asynchronous serial frames on a single input line. The line is resynchronised and then sampled on a tick that runs sixteen times per bit. The tick rate comes from a divisor register. Each frame carries a start bit, eight data bits with the least significant bit first, and one stop bit. The received byte is held in a data register until software or a DMA engine reads it. Sticky status flags record a full buffer, an idle line, a bad stop bit and a lost frame. Two enable bits route the idle flag and the error flags to a single interrupt line.

Software reaches the block through a small word-wide register port. The port has a two-bit address, read and write strobes and per-byte enables. The control register turns the receiver on, enables the idle and error interrupts, and selects DMA receive mode. In DMA receive mode, every accepted frame raises a level request. The request stays high until the data register is read with its low byte enabled. That read also frees the buffer for the next frame. A read that leaves the low byte out has no effect.

Register map (word addresses): 0 = control (bit0 receiver on, bit1 idle interrupt enable, bit2 error interrupt enable, bit3 DMA receive mode); 1 = divisor; 2 = status (bit0 data held, bit1 idle, bit2 stop-bit error, bit3 overrun); 3 = received byte in bits 7:0.

Top module: `uart_dma_rx`

## Requirements
- R1: A frame (line low for the start bit, then 8 data bits with the LSB first, then the stop bit) loads the byte into bits 7:0 of address 3 and sets status bit0.
- R2: A start is accepted only when the line is still low at the middle of the start bit. A low pulse shorter than half a bit produces no frame and no flag.
- R3: A stop bit sampled low sets status bit2.
- R4: A frame that completes while status bit0 is set sets status bit3 and leaves the held byte unchanged.
- R5: After at least one frame has been received, the line staying high for 10 bit periods sets status bit1. With no frame since the receiver was enabled, status bit1 stays 0.
- R6: irq is high exactly when (status bit1 and control bit1) or ((status bit2 or status bit3) and control bit2).
- R7: Writing 1 to status bits 1 to 3 (with the low byte enabled) clears those bits. Writing 0 leaves them unchanged.
- R8: Clearing control bit0 while a frame is in progress discards that frame. No status bit changes.
- R9: With control bit3 set, dma_req is high whenever a received byte is held, and it is low otherwise.
- R10: A read of address 3 with bus_be[0]=1 clears status bit0 and drops dma_req in the next cycle.
- R11: A read of address 3 with bus_be[0]=0 changes no state: status bit0 and dma_req keep their values.
- R12: One bit period lasts 16 times the divisor in clocks, for a divisor of 1 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables (bit0 low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| rx_in | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Combined idle and error interrupt |
| dma_req | output | 1 | Level request for DMA transfer of the held byte |

## Verification
The hardest state to reach from the ports is a second frame finishing while the first is still held. The bench forces it by sending two frames back to back without any bus read in between.

Aborting a frame partway is also awkward, because the receiver must be switched off while the line is active. The bench forks the serial driver against a control write that lands during the data bits. Once the line has gone quiet it checks that the status is still clear.

The DMA path is exercised by a monitor. The monitor answers each request with a low-byte read while the driver keeps pushing frames, and every answer is compared against a queue of expected bytes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int BUS_W   = 16;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int OVS     = 16;
    localparam int IDLE_BITS = 10;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic dma_en;
        logic err_ie;
        logic idle_ie;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic ov;
        logic fe;
        logic idle;
        logic full;
    } stat_t;

    function automatic logic [BUS_W-1:0] merge_bytes(
        input logic [BUS_W-1:0]   cur,
        input logic [BUS_W-1:0]   wd,
        input logic [BUS_W/8-1:0] be
    );
        logic [BUS_W-1:0] res;
        res = cur;
        for (int i = 0; i < BUS_W/8; i++) begin
            if (be[i]) res[8*i +: 8] = wd[8*i +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int DIV_W     = BUS_W,
    parameter int OSR       = OVS,
    parameter int DW        = DATA_W,
    parameter int IDLE_BITN = IDLE_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_en,
    input  logic [DIV_W-1:0] div,
    input  logic            rx_in,
    output logic            frame_done,
    output logic [DW-1:0]   frame_data,
    output logic            stop_ok,
    output logic            idle_hit
);
    localparam int OC_W       = $clog2(OSR);
    localparam int BN_W       = $clog2(DW);
    localparam int IDLE_TICKS = IDLE_BITN * OSR;
    localparam int IC_W       = $clog2(IDLE_TICKS);

    logic [1:0]       sync;
    logic             rx_s;
    logic [DIV_W-1:0] pc;
    logic             tick;
    rx_state_e        st;
    logic [OC_W-1:0]  oc;
    logic [BN_W-1:0]  bitn;
    logic [DW-1:0]    shreg;
    logic             seen_high;
    logic             armed;
    logic [IC_W-1:0]  idle_cnt;

    assign rx_s       = sync[1];
    assign tick       = ({1'b0, pc} + (DIV_W+1)'(1)) >= {1'b0, div};
    assign frame_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync       <= 2'b11;
            pc         <= '0;
            st         <= RX_IDLE;
            oc         <= '0;
            bitn       <= '0;
            shreg      <= '0;
            seen_high  <= 1'b0;
            armed      <= 1'b0;
            idle_cnt   <= '0;
            frame_done <= 1'b0;
            stop_ok    <= 1'b0;
            idle_hit   <= 1'b0;
        end else begin
            sync       <= {sync[0], rx_in};
            frame_done <= 1'b0;
            idle_hit   <= 1'b0;
            pc         <= tick ? '0 : pc + 1'b1;
            if (!rx_en) begin
                st        <= RX_IDLE;
                seen_high <= 1'b0;
                armed     <= 1'b0;
                idle_cnt  <= '0;
                oc        <= '0;
            end else if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (rx_s) seen_high <= 1'b1;
                        if (!rx_s && seen_high) begin
                            st        <= RX_START;
                            oc        <= '0;
                            seen_high <= 1'b0;
                            idle_cnt  <= '0;
                        end else if (armed) begin
                            if (!rx_s) begin
                                idle_cnt <= '0;
                            end else if (idle_cnt == IC_W'(IDLE_TICKS-1)) begin
                                idle_hit <= 1'b1;
                                armed    <= 1'b0;
                                idle_cnt <= '0;
                            end else begin
                                idle_cnt <= idle_cnt + 1'b1;
                            end
                        end
                    end
                    RX_START: begin
                        if (oc == OC_W'(OSR/2-1)) begin
                            oc   <= '0;
                            bitn <= '0;
                            st   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            oc <= oc + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (oc == OC_W'(OSR-1)) begin
                            oc    <= '0;
                            shreg <= {rx_s, shreg[DW-1:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == BN_W'(DW-1)) st <= RX_STOP;
                        end else begin
                            oc <= oc + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (oc == OC_W'(OSR-1)) begin
                            oc         <= '0;
                            st         <= RX_IDLE;
                            frame_done <= 1'b1;
                            stop_ok    <= rx_s;
                            armed      <= 1'b1;
                            idle_cnt   <= '0;
                        end else begin
                            oc <= oc + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter logic [BUS_W-1:0] DIV_RST = 16'd1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd,
    input  logic                wr,
    input  logic [BUS_W/8-1:0]  be,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rdata,
    input  logic                frame_done,
    input  logic [DATA_W-1:0]   frame_data,
    input  logic                stop_ok,
    input  logic                idle_hit,
    output ctrl_t               ctrl,
    output logic [BUS_W-1:0]    div,
    output stat_t               stat
);
    logic [DATA_W-1:0] held;
    logic              lo_rd;

    assign lo_rd = rd && (addr == A_DATA) && be[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            div  <= DIV_RST;
            stat <= '0;
            held <= '0;
        end else begin
            if (wr && addr == A_CTRL && be[0]) ctrl <= ctrl_t'(wdata[3:0]);
            if (wr && addr == A_DIV) div <= merge_bytes(div, wdata, be);
            if (wr && addr == A_STAT && be[0]) begin
                stat.idle <= stat.idle & ~wdata[1];
                stat.fe   <= stat.fe   & ~wdata[2];
                stat.ov   <= stat.ov   & ~wdata[3];
            end
            if (idle_hit) stat.idle <= 1'b1;
            if (lo_rd) stat.full <= 1'b0;
            if (frame_done) begin
                if (!stop_ok) stat.fe <= 1'b1;
                if (stat.full && !lo_rd) begin
                    stat.ov <= 1'b1;
                end else begin
                    held      <= frame_data;
                    stat.full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {{(BUS_W-4){1'b0}}, ctrl};
            A_DIV:   rdata = div;
            A_STAT:  rdata = {{(BUS_W-4){1'b0}}, stat};
            default: rdata = {{(BUS_W-DATA_W){1'b0}}, held};
        endcase
    end
endmodule

// File: rtl/uart_dma_rx.sv
module uart_dma_rx
    import uart_rx_pkg::*;
#(
    parameter logic [BUS_W-1:0] DIV_RST = 16'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_in,
    output logic              irq,
    output logic              dma_req
);
    ctrl_t             ctrl;
    stat_t             stat;
    logic [BUS_W-1:0]  div;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              stop_ok;
    logic              idle_hit;

    uart_rx_engine #(
        .DIV_W(BUS_W), .OSR(OVS), .DW(DATA_W), .IDLE_BITN(IDLE_BITS)
    ) u_engine (
        .clk(clk), .rst(rst), .rx_en(ctrl.rx_en), .div(div), .rx_in(rx_in),
        .frame_done(frame_done), .frame_data(frame_data),
        .stop_ok(stop_ok), .idle_hit(idle_hit)
    );

    uart_rx_regs #(.DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .be(bus_be), .wdata(bus_wdata), .rdata(bus_rdata),
        .frame_done(frame_done), .frame_data(frame_data), .stop_ok(stop_ok),
        .idle_hit(idle_hit), .ctrl(ctrl), .div(div), .stat(stat)
    );

    assign irq     = (stat.idle & ctrl.idle_ie) | ((stat.fe | stat.ov) & ctrl.err_ie);
    assign dma_req = ctrl.dma_en & stat.full;
endmodule

// File: rtl/uart_dma_rx_chk.sv
module uart_dma_rx_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_be,
    input logic              dma_req,
    input logic              dma_en,
    input logic              rx_en,
    input logic              stat_full,
    input logic              stat_fe,
    input logic              stat_ov,
    input logic              frame_done,
    input logic              stop_ok
);
    logic lo_rd;
    logic hi_only_rd;
    assign lo_rd      = bus_rd && bus_addr == A_DATA && bus_be[0];
    assign hi_only_rd = bus_rd && bus_addr == A_DATA && !bus_be[0];

    // R9
    dma_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && dma_en && !lo_rd && $stable(dma_en)) |=> dma_req);

    // R10
    lo_read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_rd && !frame_done) |=> (!dma_req && !stat_full));

    // R11
    hi_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_only_rd && stat_full) |=> stat_full);

    // R3
    stop_err_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !stop_ok) |=> stat_fe);

    // R4
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && stat_full && !lo_rd) |=> stat_ov);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !frame_done);
endmodule

bind uart_dma_rx uart_dma_rx_chk u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .dma_req(dma_req), .dma_en(ctrl.dma_en), .rx_en(ctrl.rx_en),
    .stat_full(stat.full), .stat_fe(stat.fe), .stat_ov(stat.ov),
    .frame_done(frame_done), .stop_ok(stop_ok)
);

// File: tb/sim_uart_dma_rx.sv
`timescale 1ns/1ps
module sim_uart_dma_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rx = 1'b1;
    logic        irq;
    logic        dma_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    localparam int BT = 32;

    always #2.5 clk = ~clk;

    uart_dma_rx u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata),
        .rx_in(rx), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        addr = a; wdata = d; be = b; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [1:0] b, output logic [15:0] d);
        @(negedge clk);
        addr = a; be = b; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] v, input logic stop_bit, input int bt, input bit push);
        if (push) exp_q.push_back(v);
        @(negedge clk);
        rx = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = v[i];
            repeat (bt) @(negedge clk);
        end
        rx = stop_bit;
        repeat (bt) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        bus_read(2'd0, 2'b11, d); chk("R1 reset ctrl", d, 16'h0000);
        bus_read(2'd2, 2'b11, d); chk("R1 reset status", d, 16'h0000);
        bus_read(2'd1, 2'b11, d); chk("R12 reset divisor", d, 16'h0001);
        chk("R6 reset irq", {15'b0, irq}, 16'h0);
        chk("R9 reset dma_req", {15'b0, dma_req}, 16'h0);

        bus_write(2'd1, 16'd2, 2'b11);
        bus_write(2'd0, 16'h0001, 2'b01);

        // R5: no idle flag before any frame
        repeat (12*BT) @(negedge clk);
        bus_read(2'd2, 2'b11, d); chk("R5 no idle before frame", d, 16'h0000);

        // R2: short glitch rejected
        rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
        repeat (12*BT) @(negedge clk);
        bus_read(2'd2, 2'b11, d); chk("R2 glitch ignored", d, 16'h0000);

        // R1: basic frame
        send_frame(8'hA5, 1'b1, BT, 0);
        bus_read(2'd2, 2'b11, d); chk("R1 full after frame", d, 16'h0001);
        bus_read(2'd3, 2'b11, d); chk("R1 data", d, 16'h00A5);
        bus_read(2'd2, 2'b11, d); chk("R10 full cleared by read", d, 16'h0000);

        // R5: idle after 10 bit times of high line
        repeat (6*BT) @(negedge clk);
        bus_read(2'd2, 2'b11, d); chk("R5 idle not yet", d, 16'h0000);
        repeat (5*BT) @(negedge clk);
        bus_read(2'd2, 2'b11, d); chk("R5 idle set", d, 16'h0002);
        chk("R6 irq off without enable", {15'b0, irq}, 16'h0);
        bus_write(2'd0, 16'h0003, 2'b01);
        #1 chk("R6 irq with idle enable", {15'b0, irq}, 16'h1);
        bus_write(2'd2, 16'h0000, 2'b01);
        bus_read(2'd2, 2'b11, d); chk("R7 write zero keeps flag", d, 16'h0002);
        bus_write(2'd2, 16'h0002, 2'b01);
        bus_read(2'd2, 2'b11, d); chk("R7 w1c idle", d, 16'h0000);
        chk("R6 irq drops", {15'b0, irq}, 16'h0);
        bus_write(2'd0, 16'h0001, 2'b01);

        // R4: overrun keeps first byte
        send_frame(8'h3C, 1'b1, BT, 0);
        send_frame(8'hC3, 1'b1, BT, 0);
        bus_read(2'd2, 2'b11, d); chk("R4 overrun flag", d, 16'h0009);
        bus_read(2'd3, 2'b11, d); chk("R4 held byte kept", d, 16'h003C);
        bus_write(2'd2, 16'h000E, 2'b01);
        bus_read(2'd2, 2'b11, d); chk("R7 w1c overrun", d, 16'h0000);

        // R3: stop bit low
        send_frame(8'h55, 1'b0, BT, 0);
        bus_read(2'd2, 2'b11, d); chk("R3 stop error flag", d, 16'h0005);
        chk("R6 irq off, err disabled", {15'b0, irq}, 16'h0);
        bus_write(2'd0, 16'h0005, 2'b01);
        #1 chk("R6 irq on error", {15'b0, irq}, 16'h1);
        bus_read(2'd3, 2'b11, d); chk("R3 data still delivered", d, 16'h0055);
        bus_write(2'd2, 16'h000E, 2'b01);
        bus_write(2'd0, 16'h0001, 2'b01);

        // R8: disable mid-frame
        fork
            send_frame(8'h77, 1'b1, BT, 0);
            begin
                repeat (4*BT) @(negedge clk);
                bus_write(2'd0, 16'h0000, 2'b01);
            end
        join
        bus_write(2'd0, 16'h0001, 2'b01);
        repeat (12*BT) @(negedge clk);
        bus_read(2'd2, 2'b11, d); chk("R8 aborted frame leaves status", d, 16'h0000);

        // R9/R11: DMA mode and high-byte read
        bus_write(2'd0, 16'h0009, 2'b01);
        chk("R9 no request when empty", {15'b0, dma_req}, 16'h0);
        send_frame(8'h5A, 1'b1, BT, 1);
        chk("R9 request raised", {15'b0, dma_req}, 16'h1);
        bus_read(2'd3, 2'b10, d);
        chk("R11 hi read keeps request", {15'b0, dma_req}, 16'h1);
        bus_read(2'd2, 2'b11, d); chk("R11 hi read keeps full", d, 16'h0001);

        // Scoreboard: driver and monitor
        fork
            begin
                send_frame(8'h00, 1'b1, BT, 1);
                send_frame(8'hFF, 1'b1, BT, 1);
                send_frame(8'h81, 1'b1, BT, 1);
                send_frame(8'h3C, 1'b1, BT, 1);
            end
            begin
                for (int n = 0; n < 5; n++) begin
                    logic [15:0] got;
                    logic [7:0]  want;
                    while (dma_req !== 1'b1) @(negedge clk);
                    bus_read(2'd3, 2'b01, got);
                    want = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                    chk("R9 dma byte", got, {8'h00, want});
                    chk("R10 request dropped", {15'b0, dma_req}, 16'h0);
                end
            end
        join
        bus_read(2'd2, 2'b11, d); chk("R4 no overrun under dma", d & 16'h0008, 16'h0000);

        // R12: divisor 3
        bus_write(2'd0, 16'h0001, 2'b01);
        bus_write(2'd2, 16'h000E, 2'b01);
        bus_write(2'd1, 16'd3, 2'b11);
        repeat (BT) @(negedge clk);
        send_frame(8'h96, 1'b1, 48, 0);
        bus_read(2'd2, 2'b01, d); chk("R12 full at divisor 3", d & 16'h0005, 16'h0001);
        bus_read(2'd3, 2'b11, d); chk("R12 data at divisor 3", d, 16'h0096);

        finish_run();
    end
endmodule